// File: doc/BRIEF.md
# Edge-Driven Event Down-Counter

This block counts events that arrive on an asynchronous input pin. Each selected edge on the event pin decrements a counter that runs in the system clock domain. When an event arrives while the counter holds zero, the counter reloads from a reload register and raises an underflow pending flag. A control input picks which edge of the event pin counts: rising or falling.

A second asynchronous pin serves as a separate interrupt source. Only its rising edges matter. That pin never touches the counter, and each of its rising edges raises a second pending flag. Each pending flag has its own enable, and the single interrupt request line is high while any enabled flag is pending. Flags stay set until a clear strobe removes them. The block has no waveform output, because the event pin acts as the count input.

Software writes the reload register through a load strobe, and the same write also places the value in the counter. Both pins pass through a synchronizer before any edge is detected.

Top module: `edge_event_counter`

## Requirements
- R1: While reset is held and right after it is released, the counter value, the reload register, both pending flags and the interrupt request are all zero.
- R2: With the edge select at 0, each rising edge of the event pin decrements the counter by one, and falling edges leave it unchanged.
- R3: With the edge select at 1, each falling edge of the event pin decrements the counter by one, and rising edges leave it unchanged.
- R4: A load strobe writes the load value into both the reload register and the counter at the next clock edge. It wins over a count event in the same cycle, and that event is then lost.
- R5: A count event that finds the counter at zero reloads the counter from the reload register and sets pending flag A in the same clock edge.
- R6: Each rising edge on the auxiliary pin sets pending flag B and leaves the counter unchanged. Falling edges on that pin set nothing.
- R7: The interrupt request is high exactly when flag A is pending with enable A set, or flag B is pending with enable B set. A flag that is pending but disabled raises no request.
- R8: A pending flag stays set until its clear strobe is asserted. A set event in the same cycle as the clear leaves the flag set.
- R9: A pin level change made between clock edges shows up in the counter or pending flag at the third rising clock edge after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pin | input | 1 | Asynchronous event input that drives the count |
| aux_pin | input | 1 | Asynchronous auxiliary interrupt input (rising edge) |
| edge_sel | input | 1 | Counted edge of evt_pin: 0 rising, 1 falling |
| load_stb | input | 1 | Writes load_val into the reload register and the counter |
| load_val | input | CNT_W | Value written by load_stb |
| en_a | input | 1 | Interrupt enable for the underflow flag |
| en_b | input | 1 | Interrupt enable for the auxiliary flag |
| clr_a | input | 1 | Clear strobe for the underflow flag |
| clr_b | input | 1 | Clear strobe for the auxiliary flag |
| count_q | output | CNT_W | Present counter value |
| pend_a | output | 1 | Underflow pending flag |
| pend_b | output | 1 | Auxiliary-edge pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 4-bit counter and the default two synchronizer stages. With the narrow counter, an underflow and its reload are only a few event pulses away. The two-stage depth fixes the pin-to-effect delay at three clock edges. Knowing that delay, the bench can place a load strobe or a clear strobe in exactly the cycle where an edge event lands, which exercises both same-cycle priority rules.

// File: rtl/ectr_pkg.sv
// Shared definitions for the edge-driven event counter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ectr_pkg;

    // Edge polarity chosen for a detector
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    // Number of pin inputs handled by the block
    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned PIN_EVT  = 0;
    localparam int unsigned PIN_AUX  = 1;

endpackage

// File: rtl/ectr_sync.sv
// Multi-flop synchronizer for one asynchronous level input.
// Assumes: STAGES >= 2; the input changes slowly compared to clk.
module ectr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ectr_edge.sv
// Edge detector on a synchronized level, with selectable polarity.
// Assumes: level is already synchronous to clk. The hit pulse lasts one cycle.
module ectr_edge
    import ectr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  edge_pol_e pol,
    output logic      hit
);
    logic prev_q;

    // Keep the previous synchronized sample
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Compare the present sample with the previous one for the chosen edge
    always_comb begin
        if (pol == EDGE_FALL) hit = prev_q && !level;
        else                  hit = !prev_q && level;
    end
endmodule

// File: rtl/ectr_down.sv
// Down-counter with a reload register and an underflow strobe.
// Assumes: tick is a one-cycle event pulse. load wins over tick.
module ectr_down #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    // Update the reload register and the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= ZERO;
            reload <= ZERO;
        end else if (load) begin
            count  <= load_val;
            reload <= load_val;
        end else if (tick) begin
            count  <= (count == ZERO) ? reload : count - ONE;
        end
    end

    // Flag an event that finds the counter at zero and is not overridden
    assign underflow = tick && !load && (count == ZERO);
endmodule

// File: rtl/ectr_pend.sv
// Sticky pending flag: set wins over clear.
// Assumes: set and clr are synchronous one-cycle strobes.
module ectr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag, giving set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/edge_event_counter.sv
// Top level: counts selected edges of evt_pin down to underflow and keeps
// an independent rising-edge flag for aux_pin. Drives one interrupt line.
// Assumes: both pins are asynchronous; every strobe is synchronous to clk.
module edge_event_counter
    import ectr_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pin,
    input  logic             aux_pin,
    input  logic             edge_sel,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             clr_a,
    input  logic             clr_b,
    output logic [CNT_W-1:0] count_q,
    output logic             pend_a,
    output logic             pend_b,
    output logic             irq
);
    logic [NUM_PINS-1:0] pin_raw;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_hit;
    edge_pol_e           pin_pol [NUM_PINS];
    logic [NUM_PINS-1:0] pend_set;
    logic [NUM_PINS-1:0] pend_clr;
    logic [NUM_PINS-1:0] pend_q;
    logic [CNT_W-1:0]    reload_q;
    logic                underflow;

    // Gather the pins and select each one's edge polarity
    always_comb begin
        pin_raw[PIN_EVT] = evt_pin;
        pin_raw[PIN_AUX] = aux_pin;
        pin_pol[PIN_EVT] = edge_sel ? EDGE_FALL : EDGE_RISE;
        pin_pol[PIN_AUX] = EDGE_RISE;
    end

    // One synchronizer and one edge detector per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        ectr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (pin_raw[p]),
            .q_sync  (pin_sync[p])
        );
        ectr_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .level (pin_sync[p]),
            .pol   (pin_pol[p]),
            .hit   (pin_hit[p])
        );
    end

    ectr_down #(.CNT_W(CNT_W)) u_down (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_stb),
        .load_val  (load_val),
        .tick      (pin_hit[PIN_EVT]),
        .count     (count_q),
        .reload    (reload_q),
        .underflow (underflow)
    );

    // Route the set and clear sources to the pending flags
    always_comb begin
        pend_set[PIN_EVT] = underflow;
        pend_set[PIN_AUX] = pin_hit[PIN_AUX];
        pend_clr[PIN_EVT] = clr_a;
        pend_clr[PIN_AUX] = clr_b;
    end

    for (genvar f = 0; f < NUM_PINS; f++) begin : g_pend
        ectr_pend u_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (pend_set[f]),
            .clr   (pend_clr[f]),
            .flag  (pend_q[f])
        );
    end

    // Present the flags and combine the enabled ones into the request line
    always_comb begin
        pend_a = pend_q[PIN_EVT];
        pend_b = pend_q[PIN_AUX];
        irq    = (pend_a && en_a) || (pend_b && en_b);
    end
endmodule

// File: rtl/edge_event_counter_chk.sv
// Property checker for edge_event_counter, attached through bind.
// Assumes: it observes the top's ports and a few internal nets, read-only.
module edge_event_counter_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic             evt_hit,
    input logic             aux_hit,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             pend_a,
    input logic             pend_b,
    input logic             clr_a,
    input logic             clr_b,
    input logic             en_a,
    input logic             en_b,
    input logic             irq
);
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && !evt_hit) |=> $stable(count_q)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (count_q == $past(load_val) && reload_q == $past(load_val))); // R4
    AST_UNDERFLOW_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_a) |-> (count_q == reload_q)); // R5
    AST_AUX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_b) |-> $past(aux_hit)); // R6
    AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_a || pend_b)); // R7
    AST_IRQ_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_a || en_b)); // R7
    AST_PEND_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a && !clr_a) |=> pend_a); // R8
    AST_PEND_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_b && !clr_b) |=> pend_b); // R8
endmodule

bind edge_event_counter edge_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_stb (load_stb),
    .load_val (load_val),
    .evt_hit  (pin_hit[0]),
    .aux_hit  (pin_hit[1]),
    .count_q  (count_q),
    .reload_q (reload_q),
    .pend_a   (pend_a),
    .pend_b   (pend_b),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .en_a     (en_a),
    .en_b     (en_b),
    .irq      (irq)
);

// File: tb/edge_event_counter_test.sv
// Directed bench for edge_event_counter: one task per scenario.
module edge_event_counter_test;
    localparam int unsigned W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt_pin = 1'b0, aux_pin = 1'b0, edge_sel = 1'b0;
    logic         load_stb = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         en_a = 1'b0, en_b = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic [W-1:0] count_q;
    logic         pend_a, pend_b, irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    edge_event_counter #(.CNT_W(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .aux_pin(aux_pin),
        .edge_sel(edge_sel), .load_stb(load_stb), .load_val(load_val),
        .en_a(en_a), .en_b(en_b), .clr_a(clr_a), .clr_b(clr_b),
        .count_q(count_q), .pend_a(pend_a), .pend_b(pend_b), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance one clock and return at the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_evt(input logic v);
        evt_pin = v;
        repeat (3) tick();
    endtask

    task automatic set_aux(input logic v);
        aux_pin = v;
        repeat (3) tick();
    endtask

    task automatic do_load(input int v);
        load_val = W'(v);
        load_stb = 1'b1;
        tick();
        load_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", int'(count_q), 0);
        chk("R1 pend_a", int'(pend_a), 0);
        chk("R1 pend_b", int'(pend_b), 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_latency();
        do_load(5);
        chk("R4 load", int'(count_q), 5);
        evt_pin = 1'b1;
        tick(); tick();
        chk("R9 two edges", int'(count_q), 5);
        tick();
        chk("R9 three edges", int'(count_q), 4);
        set_evt(1'b0);
        chk("R2 falling ignored", int'(count_q), 4);
    endtask

    task automatic t_rising();
        set_evt(1'b1); set_evt(1'b0);
        set_evt(1'b1); set_evt(1'b0);
        chk("R2 two rises", int'(count_q), 2);
    endtask

    task automatic t_falling();
        edge_sel = 1'b1;
        tick();
        set_evt(1'b1);
        chk("R3 rising ignored", int'(count_q), 2);
        set_evt(1'b0);
        chk("R3 falling counts", int'(count_q), 1);
        edge_sel = 1'b0;
        tick();
    endtask

    task automatic t_underflow();
        do_load(1);
        set_evt(1'b1); set_evt(1'b0);
        chk("R5 at zero", int'(count_q), 0);
        chk("R5 no flag yet", int'(pend_a), 0);
        set_evt(1'b1);
        chk("R5 reload", int'(count_q), 1);
        chk("R5 flag", int'(pend_a), 1);
        chk("R7 disabled", int'(irq), 0);
        en_a = 1'b1;
        tick();
        chk("R7 enabled A", int'(irq), 1);
        clr_a = 1'b1; tick(); clr_a = 1'b0;
        chk("R8 clear A", int'(pend_a), 0);
        chk("R7 cleared", int'(irq), 0);
        set_evt(1'b0);
    endtask

    task automatic t_aux();
        set_aux(1'b1);
        chk("R6 flag", int'(pend_b), 1);
        chk("R6 count kept", int'(count_q), 1);
        chk("R7 B disabled", int'(irq), 0);
        en_b = 1'b1;
        tick();
        chk("R7 enabled B", int'(irq), 1);
        clr_b = 1'b1; tick(); clr_b = 1'b0;
        set_aux(1'b0);
        chk("R6 falling ignored", int'(pend_b), 0);
    endtask

    task automatic t_set_wins();
        aux_pin = 1'b1;
        tick(); tick();
        clr_b = 1'b1; tick(); clr_b = 1'b0;
        chk("R8 set beats clear", int'(pend_b), 1);
        clr_b = 1'b1; tick(); clr_b = 1'b0;
        chk("R8 clear B", int'(pend_b), 0);
        set_aux(1'b0);
    endtask

    task automatic t_load_prio();
        evt_pin = 1'b1;
        tick(); tick();
        do_load(9);
        chk("R4 load beats event", int'(count_q), 9);
        repeat (3) tick();
        chk("R4 event lost", int'(count_q), 9);
        set_evt(1'b0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latency();
        t_rising();
        t_falling();
        t_underflow();
        t_aux();
        t_set_wins();
        t_load_prio();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule